// File: doc/BRIEF.md
# Shared-Period Dual PWM Timer

This block produces two pulse-width-modulated outputs that share one period. A master down-counter sets the period: it is loaded from a period register, counts toward zero on each count-clock tick, and raises a period event each time it reaches zero. On the same tick it reloads itself. Two slave channels watch that event. On each event a slave loads its duty value and starts counting down. Its output stays active while the count is running. When the slave reaches zero, the output drops and the slave waits for the next event.

Software writes period and duty values into shadow registers at any time. The counters pick up these values only on a period event, so an update never breaks a period in the middle. One-cycle start and stop pulses control the whole group. A start produces a period event on the next tick, so all three channels begin together. A stop freezes every counter and every output level where it is. Each slave has an output enable, a direct output bit used while the enable is low, and a polarity-invert input. A count-clock enable input gates every step.

Top module: `pwm_ms_timer`

## Requirements
- R1: After reset, all counters read 0, both slaves are inactive (pin level equals the invert input when enabled), and `period_evt_o` is low.
- R2: While running, each tick with `cnt_en_i` high decrements the master counter by one. On a tick where the master counter is 0, it reloads the period shadow value instead. A period value P therefore gives a period of P+1 ticks.
- R3: A `start_i` pulse makes the timer run. The first tick after it is a period event, which loads all counters from their shadows. A start while running re-arms this immediate event.
- R4: On a period-event tick a slave loads its duty value D and becomes active from the next clock. Each later tick decrements it. On the tick that takes it to 0 it becomes inactive, and it holds 0 until the next event.
- R5: A duty of 0 keeps the slave inactive for the whole period. A duty of at least P+1 keeps it active across periods without a gap.
- R6: A `stop_i` pulse halts the timer. Counters and output levels keep their current values, and the tick in the stop cycle has no effect. Stop wins over a start in the same cycle.
- R7: A period or duty write goes into a shadow register and changes nothing until the next period event. A write in the same cycle as an event takes effect at the event after that one.
- R8: While `out_en_i[k]` is 0, `pwm_o[k]` equals `out_bit_i[k]` and the timer still runs underneath.
- R9: With `invert_i[k]` at 1, the active level of `pwm_o[k]` is low and the inactive level is high.
- R10: While `cnt_en_i` is low, no counter, output level or event changes.
- R11: `period_evt_o` is high for exactly the one clock that follows each period-event tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-clock enable (one tick per high cycle) |
| start_i | input | 1 | Start pulse for all channels |
| stop_i | input | 1 | Stop pulse for all channels |
| prd_wr_i | input | 1 | Write strobe for the period shadow |
| prd_i | input | CNT_W | Period value |
| duty_wr_i | input | NUM_SL | Per-slave write strobe for the duty shadow |
| duty_i | input | CNT_W | Duty value (shared data bus) |
| out_en_i | input | NUM_SL | Per-slave output enable |
| out_bit_i | input | NUM_SL | Direct pin level used while the enable is low |
| invert_i | input | NUM_SL | Per-slave polarity invert |
| master_cnt_o | output | CNT_W | Master counter value |
| slave_cnt_o | output | NUM_SL*CNT_W | Slave counter values, slave k at bits k*CNT_W |
| pwm_o | output | NUM_SL | PWM pins |
| period_evt_o | output | 1 | Period event pulse |

## Verification
The assertions check the rules that hold on every cycle:
- a tick with the count enable low, or a stop, leaves every counter unchanged;
- a plain running tick decrements the master by exactly one;
- a halted slave stays at zero until an event;
- a start is followed by the running state and an immediate event;
- every internal event shows up on the event pin one clock later.

Only the bench's scenarios can show:
- the timing of pulse widths against the period;
- duty values of zero and of at least the period plus one;
- shadow updates waiting for the next event;
- the outputs frozen after a stop;
- output-enable and polarity handling on the pins.

// File: rtl/pwm_ms_pkg.sv
package pwm_ms_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_ARMED = 2'd1,
    M_RUN   = 2'd2
  } mstate_e;
endpackage

// File: rtl/pwm_ms_master.sv
module pwm_ms_master
  import pwm_ms_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             prd_wr_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             evt_o,
  output logic             run_o
);
  mstate_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, prd_sh_q;

  assign run_o = (st_q != M_IDLE);
  assign adv_o = run_o & tick_i & ~stop_i;
  // armed state forces the first event right after start
  assign evt_o = adv_o & ((st_q == M_ARMED) | (cnt_q == '0));
  assign cnt_o = cnt_q;

  always_comb begin
    st_d = st_q;
    if (stop_i)       st_d = M_IDLE;
    else if (start_i) st_d = M_ARMED;
    else if (evt_o)   st_d = M_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= M_IDLE;
      cnt_q    <= '0;
      prd_sh_q <= '0;
    end else begin
      st_q <= st_d;
      if (prd_wr_i) prd_sh_q <= prd_i;
      if (evt_o)      cnt_q <= prd_sh_q;
      else if (adv_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_ms_slave.sv
module pwm_ms_slave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             adv_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, duty_sh_q;
  logic             act_q;

  assign cnt_o = cnt_q;
  assign act_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      duty_sh_q <= '0;
      act_q     <= 1'b0;
    end else begin
      if (duty_wr_i) duty_sh_q <= duty_i;
      if (evt_i) begin
        cnt_q <= duty_sh_q;
        act_q <= (duty_sh_q != '0);
      end else if (adv_i && act_q) begin
        // one-shot: halts at zero until the next event
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == ONE) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_ms_timer.sv
module pwm_ms_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_SL = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cnt_en_i,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    prd_wr_i,
  input  logic [CNT_W-1:0]        prd_i,
  input  logic [NUM_SL-1:0]       duty_wr_i,
  input  logic [CNT_W-1:0]        duty_i,
  input  logic [NUM_SL-1:0]       out_en_i,
  input  logic [NUM_SL-1:0]       out_bit_i,
  input  logic [NUM_SL-1:0]       invert_i,
  output logic [CNT_W-1:0]        master_cnt_o,
  output logic [NUM_SL*CNT_W-1:0] slave_cnt_o,
  output logic [NUM_SL-1:0]       pwm_o,
  output logic                    period_evt_o
);
  logic              run, adv, evt;
  logic [NUM_SL-1:0] act;

  pwm_ms_master #(.CNT_W(CNT_W)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cnt_en_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .prd_wr_i (prd_wr_i),
    .prd_i    (prd_i),
    .cnt_o    (master_cnt_o),
    .adv_o    (adv),
    .evt_o    (evt),
    .run_o    (run)
  );

  for (genvar k = 0; k < NUM_SL; k++) begin : g_sl
    pwm_ms_slave #(.CNT_W(CNT_W)) u_slave (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt),
      .adv_i     (adv),
      .duty_wr_i (duty_wr_i[k]),
      .duty_i    (duty_i),
      .cnt_o     (slave_cnt_o[k*CNT_W +: CNT_W]),
      .act_o     (act[k])
    );
    assign pwm_o[k] = out_en_i[k] ? (act[k] ^ invert_i[k]) : out_bit_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) period_evt_o <= 1'b0;
    else         period_evt_o <= evt;
  end
endmodule

// File: rtl/pwm_ms_timer_chk.sv
module pwm_ms_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_SL = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cnt_en_i,
  input logic                    start_i,
  input logic                    stop_i,
  input logic                    run_i,
  input logic                    evt_i,
  input logic                    evt_o,
  input logic [CNT_W-1:0]        master_cnt_o,
  input logic [NUM_SL*CNT_W-1:0] slave_cnt_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> ($stable(master_cnt_o) && $stable(slave_cnt_o)));

  p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> ($stable(master_cnt_o) && $stable(slave_cnt_o) && !run_i));

  p_mdec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_en_i && !stop_i && !start_i && !evt_i)
      |=> (master_cnt_o == $past(master_cnt_o) - 1'b1));

  p_start_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> run_i);

  p_first_evt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_i) && cnt_en_i && !stop_i) |-> evt_i);

  p_evt_pin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> evt_o);

  for (genvar k = 0; k < NUM_SL; k++) begin : g_chk
    p_slave_halt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((slave_cnt_o[k*CNT_W +: CNT_W] == '0) && !evt_i)
        |=> (slave_cnt_o[k*CNT_W +: CNT_W] == '0));
  end
endmodule

bind pwm_ms_timer pwm_ms_timer_chk #(.CNT_W(CNT_W), .NUM_SL(NUM_SL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_en_i     (cnt_en_i),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .run_i        (run),
  .evt_i        (evt),
  .evt_o        (period_evt_o),
  .master_cnt_o (master_cnt_o),
  .slave_cnt_o  (slave_cnt_o)
);

// File: tb/sim_pwm_ms_timer.sv
`timescale 1ns/1ps
module sim_pwm_ms_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, prd_wr_i = 1'b0;
  logic [15:0] prd_i = '0, duty_i = '0;
  logic [1:0]  duty_wr_i = '0, out_en_i = 2'b11, out_bit_i = '0, invert_i = '0;
  logic [15:0] master_cnt_o;
  logic [31:0] slave_cnt_o;
  logic [1:0]  pwm_o;
  logic        period_evt_o;

  pwm_ms_timer u0 (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [15:0] m, s0, s1;
    logic [1:0]  pwm;
    logic        evt;
    string       req;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // stimulus staging
  logic        b_en = 1'b1, b_start = 0, b_stop = 0, b_pwr = 0;
  logic [15:0] b_prd = '0, b_duty = '0;
  logic [1:0]  b_dwr = '0, b_oe = 2'b11, b_obit = '0, b_inv = '0;

  // reference state from requirements
  logic        m_run = 0, m_first = 0;
  logic [15:0] m_cnt = 0, m_psh = 0;
  logic [15:0] m_sc[2] = '{0, 0};
  logic [15:0] m_dsh[2] = '{0, 0};
  logic [1:0]  m_act = '0;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drv(input string req);
    logic        adv, ev;
    logic [15:0] nm;
    logic [15:0] ns[2];
    logic [1:0]  na;
    exp_t        e;
    @(negedge clk_i);
    cnt_en_i = b_en; start_i = b_start; stop_i = b_stop; prd_wr_i = b_pwr;
    prd_i = b_prd; duty_wr_i = b_dwr; duty_i = b_duty;
    out_en_i = b_oe; out_bit_i = b_obit; invert_i = b_inv;
    adv = m_run && b_en && !b_stop;
    ev  = adv && (m_first || m_cnt == 0);
    nm  = ev ? m_psh : (adv ? m_cnt - 16'd1 : m_cnt);
    na  = m_act;
    for (int k = 0; k < 2; k++) begin
      ns[k] = m_sc[k];
      if (ev) begin
        ns[k] = m_dsh[k];
        na[k] = (m_dsh[k] != 0);
      end else if (adv && m_act[k]) begin
        ns[k] = m_sc[k] - 16'd1;
        na[k] = (m_sc[k] != 16'd1);
      end
    end
    if (b_stop)       begin m_run = 0; m_first = 0; end
    else if (b_start) begin m_run = 1; m_first = 1; end
    else if (ev)      m_first = 0;
    if (b_pwr) m_psh = b_prd;
    for (int k = 0; k < 2; k++) if (b_dwr[k]) m_dsh[k] = b_duty;
    m_cnt = nm; m_sc[0] = ns[0]; m_sc[1] = ns[1]; m_act = na;
    e.m = m_cnt; e.s0 = m_sc[0]; e.s1 = m_sc[1]; e.evt = ev; e.req = req;
    for (int k = 0; k < 2; k++) e.pwm[k] = b_oe[k] ? (m_act[k] ^ b_inv[k]) : b_obit[k];
    q.push_back(e);
    b_start = 0; b_stop = 0; b_pwr = 0; b_dwr = '0;
  endtask

  task automatic run_n(input int n, input string req);
    for (int i = 0; i < n; i++) drv(req);
  endtask

  // monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "master_cnt", master_cnt_o, e.m);
        check(e.req, "slave0_cnt", slave_cnt_o[15:0], e.s0);
        check(e.req, "slave1_cnt", slave_cnt_o[31:16], e.s1);
        check(e.req, "pwm", {14'd0, pwm_o}, {14'd0, e.pwm});
        check("R11", "period_evt", {15'd0, period_evt_o}, {15'd0, e.evt});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "reset master", master_cnt_o, 16'd0);
    check("R1", "reset slaves", slave_cnt_o[15:0] | slave_cnt_o[31:16], 16'd0);
    check("R1", "reset pwm", {14'd0, pwm_o}, 16'd0);
    check("R1", "reset evt", {15'd0, period_evt_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7: shadow writes before start do not move counters
    b_pwr = 1; b_prd = 16'd4; drv("R7");
    b_dwr = 2'b01; b_duty = 16'd2; drv("R7");
    b_dwr = 2'b10; b_duty = 16'd3; drv("R7");
    // R3 R2 R4: start, immediate event, periods of 5 ticks
    b_start = 1; drv("R3");
    run_n(16, "R2/R4");
    // R5 R7: duty 0 and duty >= P+1, written mid-period
    b_dwr = 2'b01; b_duty = 16'd0; drv("R7");
    b_dwr = 2'b10; b_duty = 16'd5; drv("R7");
    run_n(14, "R5");
    b_dwr = 2'b10; b_duty = 16'd9; drv("R5");
    run_n(14, "R5");
    // R7: period change mid-run
    b_pwr = 1; b_prd = 16'd6; drv("R7");
    b_dwr = 2'b01; b_duty = 16'd3; drv("R7");
    b_dwr = 2'b10; b_duty = 16'd1; drv("R7");
    run_n(18, "R7/R2");
    // R10: sparse count enable
    for (int i = 0; i < 24; i++) begin
      b_en = (i % 3 == 0); drv("R10");
    end
    b_en = 1;
    // R6: stop freezes counters and levels
    run_n(3, "R4");
    b_stop = 1; drv("R6");
    run_n(6, "R6");
    // R6: stop beats start in the same cycle
    b_start = 1; b_stop = 1; drv("R6");
    run_n(4, "R6");
    // R3: restart, then re-arm while running
    b_start = 1; drv("R3");
    run_n(4, "R3");
    b_start = 1; drv("R3");
    run_n(8, "R3/R4");
    // R8: output enable cleared, direct bit drives the pin
    b_oe = 2'b01; b_obit = 2'b10; run_n(5, "R8");
    b_obit = 2'b00; run_n(5, "R8");
    b_oe = 2'b10; b_obit = 2'b01; run_n(6, "R8");
    b_oe = 2'b11;
    // R9: polarity invert set while stopped
    b_stop = 1; drv("R9");
    b_inv = 2'b11; drv("R9");
    b_start = 1; drv("R9");
    run_n(16, "R9");
    b_inv = 2'b00;
    b_stop = 1; drv("R6");
    drv("R6");
    b_start = 1; drv("R3");
    // R2: period 0 gives an event on every tick
    b_pwr = 1; b_prd = 16'd0; drv("R2");
    run_n(10, "R2");

    while (q.size() > 0) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule